// File: doc/BRIEF.md
# Schedule-Driven Source-Routed Crossbar Router

This router moves fixed-size flits from a set of input ports to a set of output ports with no arbiter, no contention logic and no output buffering. Each flit is three words long. A word travels on a port together with a valid bit, a two-bit word index (0, 1 or 2 within its flit) and an end-of-packet mark. The route is carried in the first word of a packet as a list of 3-bit hops. The router consumes the lowest hop to choose its output and shifts the list down before sending it on. All later words of the packet follow the output latched from that first word until the end-of-packet mark releases it.

The network relies on a global slot schedule that never lets two inputs reach the same output in the same word cycle. Every word leaves the router exactly one flit time (three clock cycles) after it arrives, so a reservation moves by one slot per hop. If the schedule is broken and two inputs meet, the lower-numbered input is forwarded and a clash flag is raised on that output. The flag exists for checking only.

Top module: `src_router`

## Requirements
- R1: A valid input word appears on its selected output exactly 3 clock cycles after it is sampled, with its word index and end-of-packet mark unchanged. No output is valid unless some input was valid 3 cycles earlier.
- R2: A header word is a valid word with index 0 that arrives on an input with no open packet. Bits [2:0] of the header word select the output. The word is forwarded shifted right by 3 bits, with zeros filling the top.
- R3: Every non-header word of an open packet goes to the output latched from that packet's header, including later index-0 words, and is forwarded unmodified.
- R4: A valid word carrying the end-of-packet mark closes the packet, so the next valid index-0 word on that input is a new header. A header word that carries the mark forms a single-word packet.
- R5: When several inputs reach the same output in the same cycle, the word from the lowest-numbered input is forwarded.
- R6: The clash flag of an output is high in exactly the cycles in which two or more inputs reach that output, and only while that output is valid.
- R7: A header selecting an output number at or above N_PORTS is dropped. The rest of its packet is dropped too, and no output shows any of its words.
- R8: During reset and for the 3 cycles after it, all outputs are zero. Reset also closes any open packet.
- R9: When an output is not valid, its index, word, end-of-packet and clash bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | N_PORTS | Word valid, one bit per input |
| in_idx | input | 2*N_PORTS | Word index within the flit, 2 bits per input |
| in_word | input | WORD_W*N_PORTS | Word data, WORD_W bits per input |
| in_eop | input | N_PORTS | End-of-packet mark, one bit per input |
| out_vld | output | N_PORTS | Word valid, one bit per output |
| out_idx | output | 2*N_PORTS | Word index, 2 bits per output |
| out_word | output | WORD_W*N_PORTS | Word data, WORD_W bits per output |
| out_eop | output | N_PORTS | End-of-packet mark, one bit per output |
| out_clash | output | N_PORTS | Two or more inputs reached this output this cycle |

## Verification
The only internal state is the open-packet flag and latched output of each input, plus the three-stage word pipeline. A wrong open-packet flag shows up on the first later index-0 word: that word either misroutes to the output named by its own low bits, or it arrives with its low three bits missing. The shift appears on the port exactly three cycles later. A pipeline of the wrong depth shifts every word off the expected cycle at once, and a wrong priority or clash detector shows on the first forced collision. Expected values therefore come from a cycle-exact bench model that is compared on every cycle.

// File: rtl/src_router.sv
module src_router #(
  parameter int N_PORTS = 4,
  parameter int WORD_W  = 32,
  parameter int HOP_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_PORTS-1:0]          in_vld,
  input  logic [N_PORTS*2-1:0]        in_idx,
  input  logic [N_PORTS*WORD_W-1:0]   in_word,
  input  logic [N_PORTS-1:0]          in_eop,
  output logic [N_PORTS-1:0]          out_vld,
  output logic [N_PORTS*2-1:0]        out_idx,
  output logic [N_PORTS*WORD_W-1:0]   out_word,
  output logic [N_PORTS-1:0]          out_eop,
  output logic [N_PORTS-1:0]          out_clash
);
  localparam int FLIT_WORDS = 3;
  localparam int IDX_W      = 2;

  typedef struct packed {
    logic              vld;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] word;
    logic              eop;
    logic [HOP_W-1:0]  port;
  } slot_t;

  slot_t tail [N_PORTS];

  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    logic              vld_i, eop_i, busy, hdr;
    logic [IDX_W-1:0]  idx_i;
    logic [WORD_W-1:0] w_i;
    logic [HOP_W-1:0]  lat;
    slot_t             nx;
    slot_t             stg [FLIT_WORDS];

    assign vld_i = in_vld[i];
    assign eop_i = in_eop[i];
    assign idx_i = in_idx[i*IDX_W +: IDX_W];
    assign w_i   = in_word[i*WORD_W +: WORD_W];
    assign hdr   = vld_i && (idx_i == '0) && !busy;

    assign nx.vld  = vld_i;
    assign nx.idx  = idx_i;
    assign nx.eop  = eop_i;
    assign nx.word = hdr ? (w_i >> HOP_W) : w_i;
    assign nx.port = hdr ? w_i[HOP_W-1:0] : lat;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy <= 1'b0;
        lat  <= '0;
        for (int k = 0; k < FLIT_WORDS; k++) stg[k] <= '0;
      end else begin
        if (vld_i) begin
          if (eop_i)    busy <= 1'b0;
          else if (hdr) busy <= 1'b1;
          if (hdr)      lat  <= w_i[HOP_W-1:0];
        end
        stg[0] <= nx;
        for (int k = 1; k < FLIT_WORDS; k++) stg[k] <= stg[k-1];
      end
    end

    assign tail[i] = stg[FLIT_WORDS-1];
  end

  always_comb begin
    out_vld   = '0;
    out_idx   = '0;
    out_word  = '0;
    out_eop   = '0;
    out_clash = '0;
    for (int o = 0; o < N_PORTS; o++) begin
      for (int i = 0; i < N_PORTS; i++) begin
        if (tail[i].vld && tail[i].port == HOP_W'(o)) begin
          if (!out_vld[o]) begin
            out_vld[o]                   = 1'b1;
            out_idx[o*IDX_W +: IDX_W]    = tail[i].idx;
            out_word[o*WORD_W +: WORD_W] = tail[i].word;
            out_eop[o]                   = tail[i].eop;
          end else begin
            out_clash[o] = 1'b1;
          end
        end
      end
    end
  end
endmodule

module src_router_chk #(
  parameter int N_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_PORTS-1:0]   in_vld,
  input logic [N_PORTS-1:0]   out_vld,
  input logic [N_PORTS*2-1:0] out_idx,
  input logic [N_PORTS-1:0]   out_clash
);
  // R1
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld != '0) |-> ($past(in_vld, 3) != '0));

  // R1
  out_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_vld) <= $countones($past(in_vld, 3)));

  // R6
  clash_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_clash & ~out_vld) == '0);

  // R8
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (out_vld == '0 && out_clash == '0));

  for (genvar o = 0; o < N_PORTS; o++) begin : g_o
    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[o] |-> (out_idx[o*2 +: 2] < 2'd3));
  end
endmodule

bind src_router src_router_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
  .out_vld(out_vld), .out_idx(out_idx), .out_clash(out_clash)
);

// File: tb/sim_src_router.sv
module sim_src_router;
  localparam int N = 4;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   in_vld = '0;
  logic [N*2-1:0] in_idx = '0;
  logic [N*W-1:0] in_word = '0;
  logic [N-1:0]   in_eop = '0;
  logic [N-1:0]   out_vld, out_eop, out_clash;
  logic [N*2-1:0] out_idx;
  logic [N*W-1:0] out_word;

  always #5 clk = ~clk;

  src_router #(.N_PORTS(N), .WORD_W(W), .HOP_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_idx(in_idx),
    .in_word(in_word), .in_eop(in_eop), .out_vld(out_vld),
    .out_idx(out_idx), .out_word(out_word), .out_eop(out_eop),
    .out_clash(out_clash)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic         nv [N];
  logic [1:0]   ni [N];
  logic [W-1:0] nw [N];
  logic         ne [N];

  logic         mbusy [N];
  logic [2:0]   mlat  [N];

  logic [N-1:0]   ev [4];
  logic [N*2-1:0] ei [4];
  logic [N*W-1:0] ew [4];
  logic [N-1:0]   ee [4];
  logic [N-1:0]   ec [4];

  int gpos [N];
  int glen [N];

  function automatic logic [W-1:0] hdr_word(input logic [2:0] port, input logic [W-4:0] rest);
    return {rest, port};
  endfunction

  task automatic clear_model();
    for (int i = 0; i < N; i++) begin
      mbusy[i] = 1'b0; mlat[i] = '0;
      nv[i] = 1'b0; ni[i] = '0; nw[i] = '0; ne[i] = 1'b0;
      gpos[i] = 0; glen[i] = 3;
    end
    for (int s = 0; s < 4; s++) begin
      ev[s] = '0; ei[s] = '0; ew[s] = '0; ee[s] = '0; ec[s] = '0;
    end
  endtask

  task automatic check(input string tag, input logic ok, input string what,
                       input logic [N*W-1:0] got, input logic [N*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, got, exp);
    end
  endtask

  task automatic step(input string tag);
    int s, t;
    logic hdr;
    logic [2:0] p;
    logic [W-1:0] d;
    @(negedge clk);
    s = cyc % 4;
    check(tag, out_vld == ev[s] && out_idx == ei[s] && out_eop == ee[s], "vld/idx/eop",
          {out_vld, out_idx, out_eop}, {ev[s], ei[s], ee[s]});
    check(tag, out_word == ew[s], "word", out_word, ew[s]);
    check("R6", out_clash == ec[s], "clash", out_clash, ec[s]);
    for (int i = 0; i < N; i++) begin
      in_vld[i] = nv[i];
      in_idx[i*2 +: 2] = ni[i];
      in_word[i*W +: W] = nw[i];
      in_eop[i] = ne[i];
    end
    t = (cyc + 3) % 4;
    ev[t] = '0; ei[t] = '0; ew[t] = '0; ee[t] = '0; ec[t] = '0;
    for (int i = 0; i < N; i++) begin
      if (nv[i]) begin
        hdr = (ni[i] == 2'd0) && !mbusy[i];
        p = hdr ? nw[i][2:0] : mlat[i];
        d = hdr ? (nw[i] >> 3) : nw[i];
        if (hdr) begin mlat[i] = p; mbusy[i] = 1'b1; end
        if (ne[i]) mbusy[i] = 1'b0;
        if (p < N) begin
          if (!ev[t][p]) begin
            ev[t][p] = 1'b1;
            ei[t][p*2 +: 2] = ni[i];
            ew[t][p*W +: W] = d;
            ee[t][p] = ne[i];
          end else begin
            ec[t][p] = 1'b1;
          end
        end
      end
    end
    cyc++;
  endtask

  task automatic idle_inputs();
    for (int i = 0; i < N; i++) begin
      nv[i] = 1'b0; ni[i] = '0; nw[i] = '0; ne[i] = 1'b0;
    end
  endtask

  task automatic set_in(input int i, input logic [1:0] idx, input logic [W-1:0] w, input logic eop);
    nv[i] = 1'b1; ni[i] = idx; nw[i] = w; ne[i] = eop;
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst_n = 1'b0;
    in_vld = '0; in_idx = '0; in_word = '0; in_eop = '0;
    clear_model();
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      // R8
      check("R8", out_vld == '0 && out_word == '0 && out_clash == '0, "reset outputs",
            {out_vld, out_clash}, '0);
    end
    rst_n = 1'b1;
  endtask

  task automatic random_step();
    idle_inputs();
    for (int i = 0; i < N; i++) begin
      if ($urandom_range(0, 9) < 7) begin
        if (gpos[i] == 0) glen[i] = 3 * $urandom_range(1, 3);
        set_in(i, 2'(gpos[i] % 3), $urandom, gpos[i] == glen[i] - 1);
        gpos[i] = (gpos[i] == glen[i] - 1) ? 0 : gpos[i] + 1;
      end
    end
    step("R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear_model();
    do_reset(3);

    // R9: idle inputs keep outputs zero
    idle_inputs();
    repeat (4) step("R9");

    // R2: single-word packet, port 2, path shifted down
    set_in(0, 2'd0, hdr_word(3'd2, 29'h0ABCDE5), 1'b1);
    step("R2");
    idle_inputs();
    repeat (4) step("R2");

    // R3: multi-flit packet keeps port 3 for a later index-0 word with low bits 001
    set_in(1, 2'd0, hdr_word(3'd3, 29'h5), 1'b0); step("R3");
    set_in(1, 2'd1, 32'h1111_1111, 1'b0); step("R3");
    set_in(1, 2'd2, 32'h2222_2222, 1'b0); step("R3");
    set_in(1, 2'd0, 32'h3333_3331, 1'b0); step("R3");
    set_in(1, 2'd1, 32'h4444_4444, 1'b0); step("R3");
    set_in(1, 2'd2, 32'h5555_5555, 1'b1); step("R4");
    // R4: next index-0 word is a new header to port 0
    set_in(1, 2'd0, hdr_word(3'd0, 29'h7), 1'b1); step("R4");
    idle_inputs();
    repeat (4) step("R4");

    // R5: inputs 0 and 2 both target port 1, input 0 wins and clash flags
    set_in(0, 2'd0, hdr_word(3'd1, 29'hAA), 1'b1);
    set_in(2, 2'd0, hdr_word(3'd1, 29'hBB), 1'b1);
    set_in(3, 2'd0, hdr_word(3'd2, 29'hCC), 1'b1);
    step("R5");
    idle_inputs();
    repeat (4) step("R5");

    // R7: header to port 6 and its follow-on words are dropped
    set_in(2, 2'd0, hdr_word(3'd6, 29'h1), 1'b0); step("R7");
    set_in(2, 2'd1, 32'h0000_0000, 1'b0); step("R7");
    set_in(2, 2'd2, 32'h0000_0001, 1'b1); step("R7");
    idle_inputs();
    repeat (4) step("R7");

    // R8: reset mid-packet closes the packet
    set_in(3, 2'd0, hdr_word(3'd2, 29'h9), 1'b0); step("R8");
    set_in(3, 2'd1, 32'hDEAD_BEEF, 1'b0); step("R8");
    do_reset(2);
    set_in(3, 2'd0, hdr_word(3'd1, 29'h3), 1'b1); step("R8");
    idle_inputs();
    repeat (4) step("R8");

    // R1: constrained random traffic
    for (int k = 0; k < 3000; k++) random_step();
    idle_inputs();
    repeat (4) step("R1");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule